// File: doc/BRIEF.md
# Widening Shift-Left Vector Unit

This unit takes one 64-bit half of a 128-bit vector, treats it as a row of narrow integer elements, and turns each into an element of twice the width. Each element is first widened by sign or zero extension. It is then shifted left either by an immediate amount or by exactly its own source width. The result fills a full 128-bit vector of wide elements.

A two-bit size code selects 8-, 16- or 32-bit source elements. A half-select input chooses whether the elements come from the lower or the upper 64 bits of the source. The fourth size code has no legal meaning. The unit reports it on a flag instead of producing data.

The unit is meant to sit in the execute stage of a vector datapath, after instruction decode. One operation is accepted per clock, and each result is registered.

Top module: `simd_widen_shl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` and `bad_size` are low and `dst_vec` is all zeros.
- R2: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R3: Size code 0, 1 or 2 gives source elements of 8, 16 or 32 bits (W) and 8, 4 or 2 lanes. Output lane i occupies `dst_vec[i*2W +: 2W]`.
- R4: With `upper_half` low, source element i is taken from `src_vec[i*W +: W]`. With `upper_half` high, it is taken from element (lane count + i), which lies within bits 127:64.
- R5: With `sign_ext` high, each source element is sign-extended to 2W bits before the shift. With `sign_ext` low, it is zero-extended.
- R6: With `max_shift` high, each lane is shifted left by exactly W and `shamt` has no effect, so the low W bits of every output lane are zero.
- R7: With `max_shift` low, the shift is the low log2(W) bits of `shamt`. Higher bits of `shamt` are ignored, and bits shifted past 2W are discarded.
- R8: Size code 3 is illegal. An accepted operation with it produces `bad_size` high together with `out_valid`, and `dst_vec` all zeros. `bad_size` is never high without `out_valid`.
- R9: In a cycle after one with `in_valid` low, `dst_vec` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src_vec | input | 128 | Source vector of narrow elements |
| size_code | input | 2 | Source element size: 0=8, 1=16, 2=32 bits, 3=illegal |
| upper_half | input | 1 | 1 selects the upper 64 bits as the element source |
| sign_ext | input | 1 | 1 sign-extends, 0 zero-extends |
| max_shift | input | 1 | 1 shifts by the source element width |
| shamt | input | 5 | Immediate shift amount |
| out_valid | output | 1 | Registered result valid |
| dst_vec | output | 128 | Registered vector of wide elements |
| bad_size | output | 1 | Registered illegal-size flag |

## Verification
The assertions assume that `size_code`, `upper_half` and the other operation fields are driven to known values whenever `in_valid` is high. They also assume that reset is held for at least one clock. The bench changes every input only at falling edges and keeps `in_valid` low during reset. Random operations draw `shamt` across its full five-bit range, so immediates wider than the element width are exercised. Size code 3 and maximum-shift operations are drawn alongside the legal sizes, so the flag and zero-low-bits properties are all reached.

// File: rtl/simd_wsl_pkg.sv
package simd_wsl_pkg;
  localparam int VEC_W     = 128;
  localparam int HALF_W    = VEC_W / 2;
  localparam int NUM_SIZES = 3;
  localparam int MIN_EW    = 8;
  localparam int SHAMT_W   = $clog2(MIN_EW << (NUM_SIZES - 1));

  typedef logic [1:0] size_code_t;

  function automatic int src_width(input int k);
    return MIN_EW << k;
  endfunction
endpackage

// File: rtl/wsl_half_pick.sv
module wsl_half_pick #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   vec_i,
  input  logic               upper_i,
  output logic [VEC_W/2-1:0] half_o
);
  localparam int HW = VEC_W / 2;

  always_comb begin
    if (upper_i) half_o = vec_i[VEC_W-1:HW];
    else         half_o = vec_i[HW-1:0];
  end
endmodule

// File: rtl/wsl_lane_unit.sv
module wsl_lane_unit #(
  parameter int HALF_W = 64,
  parameter int SRC_W  = 8
) (
  input  logic [HALF_W-1:0]          half_i,
  input  logic                       sign_i,
  input  logic                       max_i,
  input  logic [$clog2(SRC_W)-1:0]   shamt_i,
  output logic [2*HALF_W-1:0]        wide_o
);
  localparam int LANES = HALF_W / SRC_W;
  localparam int DST_W = 2 * SRC_W;
  localparam int SH_W  = $clog2(SRC_W) + 1;

  logic [SH_W-1:0] sh_amt;

  always_comb begin
    if (max_i) sh_amt = SH_W'(SRC_W);
    else       sh_amt = {1'b0, shamt_i};
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [SRC_W-1:0] elem;
      logic [DST_W-1:0] ext;
      always_comb begin
        elem = half_i[g*SRC_W +: SRC_W];
        ext  = {{SRC_W{sign_i & elem[SRC_W-1]}}, elem};
        wide_o[g*DST_W +: DST_W] = ext << sh_amt;
      end
    end
  endgenerate
endmodule

// File: rtl/simd_widen_shl.sv
module simd_widen_shl
  import simd_wsl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [VEC_W-1:0]    src_vec,
  input  logic [1:0]          size_code,
  input  logic                upper_half,
  input  logic                sign_ext,
  input  logic                max_shift,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic                out_valid,
  output logic [VEC_W-1:0]    dst_vec,
  output logic                bad_size
);
  logic [HALF_W-1:0] half;
  logic [VEC_W-1:0]  lane_res [NUM_SIZES];
  logic [VEC_W-1:0]  nxt_vec;
  logic              nxt_bad;

  wsl_half_pick #(.VEC_W(VEC_W)) u_pick (
    .vec_i   (src_vec),
    .upper_i (upper_half),
    .half_o  (half)
  );

  genvar k;
  generate
    for (k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int SW = src_width(k);
      wsl_lane_unit #(.HALF_W(HALF_W), .SRC_W(SW)) u_lanes (
        .half_i  (half),
        .sign_i  (sign_ext),
        .max_i   (max_shift),
        .shamt_i (shamt[$clog2(SW)-1:0]),
        .wide_o  (lane_res[k])
      );
    end
  endgenerate

  always_comb begin
    nxt_vec = '0;
    nxt_bad = 1'b1;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (size_code == size_code_t'(s)) begin
        nxt_vec = lane_res[s];
        nxt_bad = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      bad_size  <= 1'b0;
      dst_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      bad_size  <= in_valid & nxt_bad;
      if (in_valid) dst_vec <= nxt_vec;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dst_vec));

  // R8
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_code == 2'd3) |=> (bad_size && dst_vec == '0));

  // R8
  bad_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    bad_size |-> out_valid);

  // R6
  max_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && max_shift && size_code == 2'd2) |=>
      (dst_vec[HALF_W/2-1:0] == '0 && dst_vec[HALF_W +: HALF_W/2] == '0));
endmodule

// File: tb/sim_simd_widen_shl.sv
module sim_simd_widen_shl;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] src_vec;
  logic [1:0]   size_code;
  logic         upper_half, sign_ext, max_shift;
  logic [4:0]   shamt;
  logic         out_valid, bad_size;
  logic [127:0] dst_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_widen_shl u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .size_code(size_code), .upper_half(upper_half), .sign_ext(sign_ext),
    .max_shift(max_shift), .shamt(shamt), .out_valid(out_valid),
    .dst_vec(dst_vec), .bad_size(bad_size)
  );

  function automatic logic [127:0] model(input logic [127:0] src, input int sz,
      input bit hi, input bit sgn, input bit mx, input int sh);
    logic [127:0] res = '0;
    int w, n, off, s;
    logic [63:0] mask, wmask, e, v;
    if (sz > 2) return '0;
    w = 8 << sz;
    n = 8 >> sz;
    off = hi ? n : 0;
    mask  = (64'd1 << w) - 64'd1;
    wmask = (2*w == 64) ? {64{1'b1}} : ((64'd1 << (2*w)) - 64'd1);
    s = mx ? w : (sh % w);
    for (int i = 0; i < n; i++) begin
      e = 64'(src >> ((off + i) * w)) & mask;
      if (sgn && e[w-1]) e = e | ~mask;
      v = (e << s) & wmask;
      res = res | (128'(v) << (i * 2 * w));
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [127:0] src, input int sz,
      input bit hi, input bit sgn, input bit mx, input int sh);
    @(negedge clk);
    in_valid = 1'b1; src_vec = src; size_code = sz[1:0];
    upper_half = hi; sign_ext = sgn; max_shift = mx; shamt = sh[4:0];
    @(negedge clk);
    in_valid = 1'b0;
    check(req, dst_vec, model(src, sz, hi, sgn, mx, sh));
    check({req, " valid"}, {127'd0, out_valid}, 128'd1);
    check({req, " flag"}, {127'd0, bad_size}, {127'd0, sz == 3});
  endtask

  initial begin
    logic [127:0] pat, held;
    void'($urandom(32'd20250607));
    rst = 1'b1; in_valid = 1'b0; src_vec = '0; size_code = '0;
    upper_half = 0; sign_ext = 0; max_shift = 0; shamt = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1", {dst_vec[125:0], out_valid, bad_size}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {dst_vec[125:0], out_valid, bad_size}, '0);

    pat = 128'hF1E2D3C4_B5A69788_7F80017E_02FD8003;
    // R3 R5: 8-bit low half, signed, no shift
    run_op("R5", pat, 0, 0, 1, 0, 0);
    run_op("R5", pat, 0, 0, 0, 0, 0);
    // R4: upper half at each size
    run_op("R4", pat, 0, 1, 1, 0, 3);
    run_op("R4", pat, 1, 1, 0, 0, 5);
    run_op("R4", pat, 2, 1, 1, 0, 17);
    // R3: 16 and 32 bit lanes
    run_op("R3", pat, 1, 0, 1, 0, 15);
    run_op("R3", pat, 2, 0, 0, 0, 31);
    // R6: max shift ignores shamt
    run_op("R6", pat, 0, 0, 1, 1, 5);
    run_op("R6", pat, 1, 1, 1, 1, 0);
    run_op("R6", {128{1'b1}}, 2, 0, 1, 1, 9);
    // R7: shamt above element width wraps to low bits
    run_op("R7", pat, 0, 0, 1, 0, 29);
    run_op("R7", pat, 1, 1, 0, 0, 18);
    // R8: illegal size
    run_op("R8", pat, 3, 0, 1, 0, 2);
    // R9: hold while idle
    run_op("R9", pat, 2, 1, 0, 0, 4);
    held = dst_vec;
    @(negedge clk); src_vec = ~pat; size_code = 2'd0;
    @(negedge clk);
    check("R9", dst_vec, held);
    check("R2", {127'd0, out_valid}, '0);

    for (int t = 0; t < 400; t++) begin
      pat = {$urandom, $urandom, $urandom, $urandom};
      run_op("R3", pat, int'($urandom % 4), bit'($urandom % 2),
             bit'($urandom % 2), bit'(($urandom % 5) == 0), int'($urandom % 32));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule